// File: doc/BRIEF.md
# Multi-Tap Code Replica Correlator

This block despreads a stream of complex 8-bit baseband samples against several copies of a locally stored spreading code. All copies run at one programmable chip rate, and each copy is offset in time from the others. Before correlation, each sample passes through a carrier rotator. The rotator is driven by a phase accumulator whose step can itself ramp over time. The code phase advances the same way: a per-sample step that grows by a programmable rate term.

The controlling logic first loads the code memory through a one-word programming port. It then sets the integration length, the code length, the code and carrier dynamics, and a start index and start fraction for every tap. Finally it pulses `start`. Each accepted sample adds one rotated, sign-flipped contribution to every tap's complex accumulator. When the last sample of the integration arrives, the block latches one complex sum per tap on the result ports and raises `done`.

Top module: `corr_multitap`

## Requirements
- R1: After reset, `done` is 0, every result is 0, the code memory holds all zeros, and the write pointer is 0.
- R2: A programming write with bit 28 set returns the write pointer to 0 and stores nothing. Any other programming write stores bit 0 at the pointer and then increments the pointer. A stored 1 acts as chip +1, and a stored 0 acts as chip -1.
- R3: `start` loads all configuration inputs, zeroes the accumulators and sample count, clears `done` on the next cycle and arms the block. A sample presented in the same cycle as `start` is not counted.
- R4: The carrier angle index is phase bits [31:29]. The cosine table, indexed 0 to 7, is 127, 90, 0, -90, -127, -90, 0, 90, and the sine value is the table entry at index minus 2 (mod 8). The wiped sample is re = (i·c + q·s + 64) >>> 7 and im = (q·c − i·s + 64) >>> 7, held as 16-bit values. Each tap adds the wiped sample when its chip is +1 and subtracts it when its chip is −1.
- R5: On each accepted sample, after use, the carrier phase grows by the carrier step and the step grows by the carrier rate, both modulo 2^32.
- R6: A tap's 31-bit fraction (2^31 counts = one chip) grows by the current code step on each accepted sample. A carry past 2^31 advances that tap's index by one. The code step then grows by the code rate, modulo 2^32. The code step must stay below 2^31.
- R7: A tap index that advances from the programmed last code entry wraps to 0.
- R8: The integration covers exactly length-minus-1 + 1 accepted samples. `done` and the results appear in the cycle after the final one, and not before.
- R9: A cycle with `s_valid` low changes no accumulator, phase, count or output.
- R10: While `done` is high and no `start` arrives, the results and `done` hold, and further samples are ignored.
- R11: Each tap keeps its own index and fraction, so taps with different start values accumulate independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Code programming write strobe |
| prog_data | input | 32 | Programming word: bit 28 clears the pointer, bit 0 is the chip |
| cfg_code_last | input | ADDR_W | Code length minus 1 |
| cfg_len_m1 | input | CNT_W | Integration length in samples minus 1 |
| cfg_code_step | input | 32 | Initial code step per sample, 31 fractional bits |
| cfg_code_rate | input | 32 | Signed increment added to the code step per sample |
| cfg_carr_phase | input | 32 | Initial carrier phase |
| cfg_carr_step | input | 32 | Signed initial carrier phase step |
| cfg_carr_rate | input | 32 | Signed increment added to the carrier step per sample |
| cfg_tap_index | input | N_TAPS*ADDR_W | Per-tap start code index |
| cfg_tap_frac | input | N_TAPS*31 | Per-tap start fraction |
| start | input | 1 | Begin a new integration |
| s_valid | input | 1 | Sample qualifier |
| s_i | input | 8 | Signed in-phase sample |
| s_q | input | 8 | Signed quadrature sample |
| done | output | 1 | Results latched |
| res_re | output | N_TAPS*ACC_W | Per-tap real sums, tap 0 in the low bits |
| res_im | output | N_TAPS*ACC_W | Per-tap imaginary sums, tap 0 in the low bits |

## Verification
The first pattern is a constant sample against taps that never move. Its ±40 totals show whether the clear word wrote nothing and whether the chip polarity is right. With the phase at a quarter turn, the same pattern checks the sine and cosine lookup and the sign of the imaginary term. A random sample stream with a ramping carrier and gaps in `s_valid` separates second-order phase errors from errors in how idle cycles are handled. A near-one-chip-per-sample code step over a five-entry code, with taps starting on either side of a carry, exposes faults in index wrap, carry detection and per-tap independence. A cycle model in the bench is compared against every output on every clock.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int SAMP_W      = 8;
  localparam int WIPE_W      = 16;
  localparam int FRAC_W      = 31;
  localparam int PH_W        = 32;
  localparam int LUT_AW      = 3;
  localparam int RND_SH      = 7;
  localparam int CHIP_BIT    = 0;
  localparam int CLR_PTR_BIT = 28;

  // Eight-point cosine, amplitude 127.
  function automatic logic signed [SAMP_W-1:0] cos_lut(input logic [LUT_AW-1:0] a);
    logic signed [SAMP_W-1:0] v;
    case (a)
      3'd0:    v = 8'sd127;
      3'd1:    v = 8'sd90;
      3'd2:    v = 8'sd0;
      3'd3:    v = -8'sd90;
      3'd4:    v = -8'sd127;
      3'd5:    v = -8'sd90;
      3'd6:    v = 8'sd0;
      default: v = 8'sd90;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/corr_code_mem.sv
module corr_code_mem
  import corr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_RD   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_we,
  input  logic [31:0]              prog_data,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr,
  output logic [N_RD-1:0]          rd_chip
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  mem_q, mem_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              unused_prog;

  assign unused_prog = ^prog_data;

  always_comb begin
    mem_d = mem_q;
    ptr_d = ptr_q;
    if (prog_data[CLR_PTR_BIT]) begin
      ptr_d = '0;
    end else begin
      mem_d[ptr_q] = prog_data[CHIP_BIT];
      ptr_d        = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      ptr_q <= '0;
    end else if (prog_we) begin
      mem_q <= mem_d;
      ptr_q <= ptr_d;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rd_chip[g] = mem_q[rd_addr[g*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/corr_carrier_nco.sv
module corr_carrier_nco
  import corr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     adv,
  input  logic [PH_W-1:0]          phase_init,
  input  logic [PH_W-1:0]          step_init,
  input  logic [PH_W-1:0]          rate_init,
  input  logic signed [SAMP_W-1:0] s_i,
  input  logic signed [SAMP_W-1:0] s_q,
  output logic signed [WIPE_W-1:0] wipe_re,
  output logic signed [WIPE_W-1:0] wipe_im
);
  logic [PH_W-1:0] phase_q, phase_d, step_q, step_d, rate_q, rate_d;
  logic [LUT_AW-1:0] ang;
  logic signed [SAMP_W-1:0] cv, sv;
  logic signed [WIPE_W-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [WIPE_W:0]   sum_re, sum_im, sh_re, sh_im;
  logic                     unused_sh;

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    rate_d  = rate_q;
    if (load) begin
      phase_d = phase_init;
      step_d  = step_init;
      rate_d  = rate_init;
    end else if (adv) begin
      phase_d = phase_q + step_q;
      step_d  = step_q + rate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      step_q  <= '0;
      rate_q  <= '0;
    end else if (load || adv) begin
      phase_q <= phase_d;
      step_q  <= step_d;
      rate_q  <= rate_d;
    end
  end

  always_comb begin
    ang    = phase_q[PH_W-1 -: LUT_AW];
    cv     = cos_lut(ang);
    sv     = cos_lut(ang - 3'd2);
    p_ic   = s_i * cv;
    p_qs   = s_q * sv;
    p_qc   = s_q * cv;
    p_is   = s_i * sv;
    sum_re = {p_ic[WIPE_W-1], p_ic} + {p_qs[WIPE_W-1], p_qs} + 17'sd64;
    sum_im = {p_qc[WIPE_W-1], p_qc} - {p_is[WIPE_W-1], p_is} + 17'sd64;
    sh_re  = sum_re >>> RND_SH;
    sh_im  = sum_im >>> RND_SH;
  end

  assign wipe_re   = sh_re[WIPE_W-1:0];
  assign wipe_im   = sh_im[WIPE_W-1:0];
  assign unused_sh = sh_re[WIPE_W] ^ sh_im[WIPE_W];
endmodule

// File: rtl/corr_tap.sv
module corr_tap
  import corr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     adv,
  input  logic                     latch,
  input  logic [ADDR_W-1:0]        idx_init,
  input  logic [FRAC_W-1:0]        frac_init,
  input  logic [ADDR_W-1:0]        code_last,
  input  logic [PH_W-1:0]          code_step,
  input  logic                     chip,
  input  logic signed [WIPE_W-1:0] wipe_re,
  input  logic signed [WIPE_W-1:0] wipe_im,
  output logic [ADDR_W-1:0]        idx,
  output logic [ACC_W-1:0]         res_re,
  output logic [ACC_W-1:0]         res_im
);
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [ACC_W-1:0]  acc_re_q, acc_im_q, acc_re_d, acc_im_d, sum_re, sum_im;
  logic [ACC_W-1:0]  res_re_q, res_im_q, ext_re, ext_im;
  logic [PH_W-1:0]   fsum;

  always_comb begin
    ext_re = ACC_W'(wipe_re);
    ext_im = ACC_W'(wipe_im);
    sum_re = chip ? acc_re_q + ext_re : acc_re_q - ext_re;
    sum_im = chip ? acc_im_q + ext_im : acc_im_q - ext_im;
    fsum   = {1'b0, frac_q} + code_step;
    idx_d    = idx_q;
    frac_d   = frac_q;
    acc_re_d = acc_re_q;
    acc_im_d = acc_im_q;
    if (load) begin
      idx_d    = idx_init;
      frac_d   = frac_init;
      acc_re_d = '0;
      acc_im_d = '0;
    end else if (adv) begin
      acc_re_d = sum_re;
      acc_im_d = sum_im;
      frac_d   = fsum[FRAC_W-1:0];
      if (fsum[FRAC_W]) idx_d = (idx_q == code_last) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      frac_q   <= '0;
      acc_re_q <= '0;
      acc_im_q <= '0;
    end else if (load || adv) begin
      idx_q    <= idx_d;
      frac_q   <= frac_d;
      acc_re_q <= acc_re_d;
      acc_im_q <= acc_im_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_re_q <= '0;
      res_im_q <= '0;
    end else if (latch) begin
      res_re_q <= sum_re;
      res_im_q <= sum_im;
    end
  end

  assign idx    = idx_q;
  assign res_re = res_re_q;
  assign res_im = res_im_q;
endmodule

// File: rtl/corr_multitap.sv
module corr_multitap
  import corr_pkg::*;
#(
  parameter int N_TAPS = 3,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prog_we,
  input  logic [31:0]                 prog_data,
  input  logic [ADDR_W-1:0]           cfg_code_last,
  input  logic [CNT_W-1:0]            cfg_len_m1,
  input  logic [31:0]                 cfg_code_step,
  input  logic [31:0]                 cfg_code_rate,
  input  logic [31:0]                 cfg_carr_phase,
  input  logic [31:0]                 cfg_carr_step,
  input  logic [31:0]                 cfg_carr_rate,
  input  logic [N_TAPS*ADDR_W-1:0]    cfg_tap_index,
  input  logic [N_TAPS*31-1:0]        cfg_tap_frac,
  input  logic                        start,
  input  logic                        s_valid,
  input  logic signed [7:0]           s_i,
  input  logic signed [7:0]           s_q,
  output logic                        done,
  output logic [N_TAPS*ACC_W-1:0]     res_re,
  output logic [N_TAPS*ACC_W-1:0]     res_im
);
  logic              active_q, active_d, done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic [PH_W-1:0]   cstep_q, cstep_d, crate_q, crate_d;
  logic              adv, fin;
  logic [N_TAPS*ADDR_W-1:0] tap_idx;
  logic [N_TAPS-1:0]        tap_chip;
  logic signed [WIPE_W-1:0] wipe_re, wipe_im;

  assign adv = active_q && s_valid && !start;
  assign fin = adv && (cnt_q == len_q);

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    last_d   = last_q;
    cstep_d  = cstep_q;
    crate_d  = crate_q;
    if (start) begin
      active_d = 1'b1;
      done_d   = 1'b0;
      cnt_d    = '0;
      len_d    = cfg_len_m1;
      last_d   = cfg_code_last;
      cstep_d  = cfg_code_step;
      crate_d  = cfg_code_rate;
    end else if (adv) begin
      cnt_d   = cnt_q + 1'b1;
      cstep_d = cstep_q + crate_q;
      if (fin) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      last_q   <= '0;
      cstep_q  <= '0;
      crate_q  <= '0;
    end else if (start || adv) begin
      active_q <= active_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      last_q   <= last_d;
      cstep_q  <= cstep_d;
      crate_q  <= crate_d;
    end
  end

  corr_code_mem #(.ADDR_W(ADDR_W), .N_RD(N_TAPS)) u_mem (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_data(prog_data),
    .rd_addr(tap_idx), .rd_chip(tap_chip)
  );

  corr_carrier_nco u_nco (
    .clk(clk), .rst_n(rst_n), .load(start), .adv(adv),
    .phase_init(cfg_carr_phase), .step_init(cfg_carr_step), .rate_init(cfg_carr_rate),
    .s_i(s_i), .s_q(s_q), .wipe_re(wipe_re), .wipe_im(wipe_im)
  );

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    corr_tap #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_tap (
      .clk(clk), .rst_n(rst_n), .load(start), .adv(adv), .latch(fin),
      .idx_init(cfg_tap_index[t*ADDR_W +: ADDR_W]),
      .frac_init(cfg_tap_frac[t*FRAC_W +: FRAC_W]),
      .code_last(last_q), .code_step(cstep_q), .chip(tap_chip[t]),
      .wipe_re(wipe_re), .wipe_im(wipe_im),
      .idx(tap_idx[t*ADDR_W +: ADDR_W]),
      .res_re(res_re[t*ACC_W +: ACC_W]),
      .res_im(res_im[t*ACC_W +: ACC_W])
    );
  end

  assign done = done_q;
endmodule

// File: rtl/corr_multitap_checks.sv
module corr_multitap_checks #(
  parameter int RW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          s_valid,
  input logic          done,
  input logic [RW-1:0] res_re,
  input logic [RW-1:0] res_im
);
  assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_done_after_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(s_valid) && !$past(start));

  assert_idle_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid && !start |=> $stable(done) && $stable(res_re) && $stable(res_im));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  assert_results_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(res_re) && $stable(res_im));
endmodule

bind corr_multitap corr_multitap_checks #(.RW(N_TAPS*ACC_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
  .done(done), .res_re(res_re), .res_im(res_im)
);

// File: tb/sim_corr_multitap.sv
module sim_corr_multitap;
  localparam int NT = 3, AW = 6, CW = 16, AC = 32;
  localparam longint M32 = 64'hFFFF_FFFF;
  localparam longint ONE_CHIP = 64'h8000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, prog_we, start, s_valid, done;
  logic [31:0] prog_data, c_step, c_rate, k_phase, k_step, k_rate;
  logic [AW-1:0] c_last;
  logic [CW-1:0] len_m1;
  logic [NT*AW-1:0] t_idx;
  logic [NT*31-1:0] t_frac;
  logic signed [7:0] s_i, s_q;
  logic [NT*AC-1:0] res_re, res_im;

  corr_multitap #(.N_TAPS(NT), .ADDR_W(AW), .CNT_W(CW), .ACC_W(AC)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_data(prog_data),
    .cfg_code_last(c_last), .cfg_len_m1(len_m1), .cfg_code_step(c_step),
    .cfg_code_rate(c_rate), .cfg_carr_phase(k_phase), .cfg_carr_step(k_step),
    .cfg_carr_rate(k_rate), .cfg_tap_index(t_idx), .cfg_tap_frac(t_frac),
    .start(start), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
    .done(done), .res_re(res_re), .res_im(res_im)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit finished = 0;

  // ---------------- behavioural reference model ----------------
  int     ctab[8] = '{127, 90, 0, -90, -127, -90, 0, 90};
  bit     m_mem[64];
  int     m_ptr, m_cnt, m_len, m_clast;
  bit     m_active, m_done;
  longint m_phase, m_pstep, m_prate, m_cstep, m_crate;
  int     m_idx[NT];
  longint m_frac[NT], m_acc_re[NT], m_acc_im[NT], m_res_re[NT], m_res_im[NT];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[a]) m_mem[a] = 0;
      m_ptr = 0; m_cnt = 0; m_len = 0; m_clast = 0;
      m_active = 0; m_done = 0;
      m_phase = 0; m_pstep = 0; m_prate = 0; m_cstep = 0; m_crate = 0;
      for (int k = 0; k < NT; k++) begin
        m_idx[k] = 0; m_frac[k] = 0; m_acc_re[k] = 0; m_acc_im[k] = 0;
        m_res_re[k] = 0; m_res_im[k] = 0;
      end
    end else begin
      if (prog_we) begin
        if (prog_data[28]) m_ptr = 0;
        else begin m_mem[m_ptr] = prog_data[0]; m_ptr = (m_ptr + 1) % 64; end
      end
      if (start) begin
        m_active = 1; m_done = 0; m_cnt = 0; m_len = int'(len_m1); m_clast = int'(c_last);
        m_cstep = longint'(c_step); m_crate = longint'(c_rate);
        m_phase = longint'(k_phase); m_pstep = longint'(k_step); m_prate = longint'(k_rate);
        for (int k = 0; k < NT; k++) begin
          m_idx[k] = int'(t_idx[k*AW +: AW]); m_frac[k] = longint'(t_frac[k*31 +: 31]);
          m_acc_re[k] = 0; m_acc_im[k] = 0;
        end
      end else if (m_active && s_valid) begin
        int a, c, s, wr, wi;
        a  = int'(m_phase >> 29);
        c  = ctab[a]; s = ctab[(a + 6) % 8];
        wr = (int'(s_i) * c + int'(s_q) * s + 64) >>> 7;
        wi = (int'(s_q) * c - int'(s_i) * s + 64) >>> 7;
        for (int k = 0; k < NT; k++) begin
          longint fs;
          if (m_mem[m_idx[k]]) begin m_acc_re[k] += wr; m_acc_im[k] += wi; end
          else                 begin m_acc_re[k] -= wr; m_acc_im[k] -= wi; end
          fs = m_frac[k] + m_cstep;
          if (fs >= ONE_CHIP) begin
            fs -= ONE_CHIP;
            m_idx[k] = (m_idx[k] == m_clast) ? 0 : m_idx[k] + 1;
          end
          m_frac[k] = fs;
        end
        m_phase = (m_phase + m_pstep) & M32;
        m_pstep = (m_pstep + m_prate) & M32;
        m_cstep = (m_cstep + m_crate) & M32;
        if (m_cnt == m_len) begin
          m_active = 0; m_done = 1;
          for (int k = 0; k < NT; k++) begin m_res_re[k] = m_acc_re[k]; m_res_im[k] = m_acc_im[k]; end
        end else m_cnt++;
      end
    end
  end

  function automatic longint tap_re(int k);
    return longint'($signed(res_re[k*AC +: AC]));
  endfunction
  function automatic longint tap_im(int k);
    return longint'($signed(res_im[k*AC +: AC]));
  endfunction

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ok;
      ok = (done === m_done);
      for (int k = 0; k < NT; k++)
        ok = ok && (tap_re(k) == m_res_re[k]) && (tap_im(k) == m_res_im[k]);
      n_chk++;
      if (!ok) begin
        n_err++;
        $display("FAIL %s cycle compare: done=%0d/%0d tap0 re=%0d/%0d im=%0d/%0d",
                 cur_req, done, m_done, tap_re(0), m_res_re[0], tap_im(0), m_res_im[0]);
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prog(input logic [31:0] w);
    prog_we = 1; prog_data = w;
    @(negedge clk);
    prog_we = 0; prog_data = '0;
  endtask

  int unsigned lfsr = 32'hACE1;
  task automatic next_sample();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    s_i = lfsr[7:0]; s_q = lfsr[15:8];
  endtask

  // Starts an integration and feeds len_m1+1 valid samples; gap>0 idles one cycle in gap.
  task automatic run(input int gap, input bit rnd, input bit valid_at_start);
    int fed = 0, cyc = 0;
    start = 1; s_valid = valid_at_start;
    @(negedge clk);
    start = 0;
    check("R3", "done cleared by start", done, 0);
    while (fed <= int'(len_m1)) begin
      s_valid = (gap == 0) || (cyc % gap != 0);
      if (rnd) next_sample();
      if (s_valid) fed++;
      cyc++;
      @(negedge clk);
      if (s_valid && fed == int'(len_m1)) check("R8", "done before last sample", done, 0);
    end
    s_valid = 0;
    check("R8", "done after last sample", done, 1);
  endtask

  initial begin
    int bad;
    bad = 0;
    rst_n = 0; prog_we = 0; prog_data = '0; start = 0; s_valid = 0; s_i = '0; s_q = '0;
    c_last = '0; len_m1 = '0; c_step = '0; c_rate = '0;
    k_phase = '0; k_step = '0; k_rate = '0; t_idx = '0; t_frac = '0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    for (int k = 0; k < NT; k++) begin
      check("R1", "reset result re", tap_re(k), 0);
      check("R1", "reset result im", tap_im(k), 0);
    end
    check("R1", "reset done", done, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: clear word stores nothing; chips 0,1,0 at entries 0..2.
    cur_req = "R2";
    prog(32'h1); prog(32'h1); prog(32'h1);
    prog(32'h1000_0001);
    prog(32'h0); prog(32'h1); prog(32'h0);
    c_last = 6'd15; len_m1 = 16'd3; c_step = '0; c_rate = '0;
    t_idx = {6'd2, 6'd1, 6'd0}; t_frac = '0;
    s_i = 8'sd10; s_q = 8'sd0;
    run(0, 0, 0);
    check("R2", "tap0 chip -1", tap_re(0), -40);
    check("R2", "tap1 chip +1", tap_re(1), 40);
    check("R2", "tap2 chip -1", tap_re(2), -40);

    // R4: quarter-turn phase moves energy to imaginary with negative sine sign.
    cur_req = "R4";
    k_phase = 32'h4000_0000;
    run(0, 0, 0);
    check("R4", "quarter turn re", tap_re(1), 0);
    check("R4", "quarter turn im tap0", tap_im(0), 40);
    check("R4", "quarter turn im tap1", tap_im(1), -40);

    // Full 16-chip code for the dynamic tests.
    cur_req = "R2";
    prog(32'h1000_0000);
    for (int b = 0; b < 16; b++) prog({31'd0, 1'(16'hB38E >> b)});

    // R6: half-chip step, three staggered taps, random samples.
    cur_req = "R6";
    k_phase = '0; k_step = '0; k_rate = '0;
    c_step = 32'h4000_0000; len_m1 = 16'd39;
    t_idx = {6'd5, 6'd1, 6'd0}; t_frac = {31'h2000_0000, 31'h0, 31'h6000_0000};
    run(0, 1, 0);
    check("R6", "tap2 re vs model", tap_re(2), m_res_re[2]);

    // R5 and R9: ramping carrier and code, with idle gaps.
    cur_req = "R5";
    k_phase = 32'h1000_0000; k_step = 32'h0300_0000; k_rate = 32'h0001_0000;
    c_step = 32'h5000_0000; c_rate = 32'h0010_0000; len_m1 = 16'd59;
    run(3, 1, 0);
    check("R5", "tap0 im vs model", tap_im(0), m_res_im[0]);
    check("R9", "tap1 re vs model with gaps", tap_re(1), m_res_re[1]);

    // R7 and R11: short code, nearly a chip per sample, taps either side of a carry.
    cur_req = "R7";
    c_last = 6'd4; c_step = 32'h7FFF_0000; c_rate = 32'hFFFF_FF00;
    k_phase = 32'hA000_0000; k_step = 32'hF800_0000; k_rate = '0; len_m1 = 16'd25;
    t_idx = {6'd0, 6'd2, 6'd4}; t_frac = {31'h0, 31'h4000_0000, 31'h7FFF_FFFF};
    run(0, 1, 0);
    check("R7", "tap0 wrap vs model", tap_re(0), m_res_re[0]);
    check("R11", "tap2 independent", tap_im(2), m_res_im[2]);

    // R10: samples after completion change nothing.
    cur_req = "R10";
    begin
      longint h0, h2;
      h0 = tap_re(0); h2 = tap_im(2);
      for (int n = 0; n < 6; n++) begin s_valid = 1; next_sample(); @(negedge clk); end
      s_valid = 0;
      check("R10", "held re after done", tap_re(0), h0);
      check("R10", "held im after done", tap_im(2), h2);
      check("R10", "done held", done, 1);
    end

    // R3: a sample alongside start is not counted.
    cur_req = "R3";
    len_m1 = 16'd9;
    run(0, 1, 1);
    check("R3", "tap1 re vs model", tap_re(1), m_res_re[1]);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1;
    n_chk++; n_err++;
    $display("FAIL %s watchdog expired", cur_req);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule